// File: doc/BRIEF.md
# Prioritized interrupt controller register bank

This block gathers 32 interrupt lines and exposes their state to software through a word-wide register bus. The bus has an address, a write strobe, write data and read data. Each line has three pieces of state: an enable bit, a pending bit and a 2-bit urgency value. Software changes the enable and pending bits through separate write-one-to-set and write-one-to-clear addresses. Both addresses of a pair read back the live vector. A rising edge on a hardware interrupt input marks its line pending.

The block also selects a winner. Among lines that are both pending and enabled, it picks the line with the smallest urgency value, and on a tie the lowest line number. It presents that line as a registered ID with a valid flag. A one-cycle acknowledge pulse clears the pending bit of the line being presented. Register writes take effect on the rising clock edge where the write strobe is high. Read data is combinational from the address.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, the enable vector, the pending vector and all urgency fields are zero, and `pick_valid` is low.
- R2: A write to word address 0x100 sets every enable bit whose write-data bit is 1 and leaves the other enable bits alone. A read of 0x100 returns the enable vector, with bit n for line n.
- R3: A write to 0x180 clears every enable bit whose write-data bit is 1 and leaves the other enable bits alone. A read of 0x180 also returns the enable vector.
- R4: A write to 0x200 sets the pending bits selected by ones in the write data. A write to 0x280 clears the pending bits selected by ones. Reads of either address return the pending vector.
- R5: The urgency of line 4k+j sits in bits [8j+7:8j+6] of the word at 0x400+4k, for k from 0 to 7. The other six bits of each byte read as zero and ignore writes.
- R6: An address outside the map, including any address with bits [1:0] not zero, reads as zero. A write to such an address changes no enable, pending or urgency state.
- R7: A 0-to-1 transition on `irq_in[n]` sets pending bit n on the next clock edge, whether or not line n is enabled. A level that stays high does not set the bit again after it has been cleared.
- R8: When a hardware rising edge and a software clear-pending write hit the same line in the same cycle, the line ends up pending. Other lines named in the same clear write are still cleared.
- R9: The selected line is the pending and enabled line with the smallest urgency value, where 0 is the most urgent. On a tie, the lower line number wins. A pending line that is disabled is never selected.
- R10: `pick_id` and `pick_valid` are registered. They show the choice made from the state as it stood after the previous clock edge, so they lag a state change by one cycle.
- R11: When `pick_ack` is high and `pick_valid` is high on a clock edge, the pending bit of the line named by `pick_id` is cleared on that edge.
- R12: `pick_valid` is low when no line is both pending and enabled, and `pick_id` is then zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 12 | Byte address of the word being accessed |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_in | input | 32 | Hardware interrupt inputs; a rising edge marks a line pending |
| pick_id | output | 5 | Number of the selected line |
| pick_valid | output | 1 | High when `pick_id` names a pending, enabled line |
| pick_ack | input | 1 | One-cycle pulse that clears the pending bit of the selected line |

## Verification
Some behaviours are checked by the assertions on every cycle:
- set and clear writes act on exactly the named enable bits;
- a hardware edge always leaves its line pending, even when a clear lands in the same cycle;
- an acknowledge removes the selected line's pending bit;
- reserved writes leave the enable and urgency state unchanged, and reserved reads return zero;
- the presented line was a candidate in the previous cycle, and the valid flag drops only when no candidate existed.

Other behaviours only the directed scenarios can show:
- that the winner is the most urgent candidate and that the lower line wins ties;
- the exact byte-lane placement of each urgency field;
- the one-cycle lag of the selection;
- that a high level held on an input does not set the line pending again after it is cleared.

// File: rtl/irq_ctrl_pkg.sv
// Shared constants and types for the interrupt controller register bank.
// Assumes a byte-addressed bus that always carries whole 32-bit words.
package irq_ctrl_pkg;

    localparam int unsigned BUS_DW      = 32;
    localparam int unsigned OFS_EN_SET  = 'h100;
    localparam int unsigned OFS_EN_CLR  = 'h180;
    localparam int unsigned OFS_PD_SET  = 'h200;
    localparam int unsigned OFS_PD_CLR  = 'h280;
    localparam int unsigned OFS_PRIO    = 'h400;
    localparam int unsigned LINES_PER_W = 4;

    // Which register the current bus address selects.
    typedef enum logic [2:0] {
        REG_NONE,
        REG_EN_SET,
        REG_EN_CLR,
        REG_PD_SET,
        REG_PD_CLR,
        REG_PRIO
    } reg_sel_e;

endpackage

// File: rtl/irq_line_state.sv
// Per-line enable and pending state.
// - Enable bits change only through the set and clear masks.
// - Pending bits are set by software, or by a rising edge on the hardware input.
//   They are cleared by software or by an acknowledge.
// - A hardware edge wins over any clear in the same cycle.
// Assumes the masks are already qualified by the bus write strobe.
module irq_line_state #(
    parameter int NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] en_set,
    input  logic [NUM_LINES-1:0] en_clr,
    input  logic [NUM_LINES-1:0] pd_set,
    input  logic [NUM_LINES-1:0] pd_clr,
    input  logic [NUM_LINES-1:0] ack_clr,
    input  logic [NUM_LINES-1:0] irq_in,
    output logic [NUM_LINES-1:0] en_q,
    output logic [NUM_LINES-1:0] pend_q
);

    logic [NUM_LINES-1:0] irq_q;
    logic [NUM_LINES-1:0] hw_edge;

    // Rising-edge detect on the hardware inputs.
    assign hw_edge = irq_in & ~irq_q;

    // Remember last cycle's input levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_in;
    end

    // Enable vector: set and clear by mask.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= (en_q & ~en_clr) | en_set;
    end

    // Pending vector: clears first, then software and hardware sets on top.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~(pd_clr | ack_clr)) | pd_set | hw_edge;
    end

    // R2: set-enable bits are present after the edge.
    p_en_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_set != '0) |=> ((en_q & $past(en_set)) == $past(en_set)));

    // R3: clear-enable bits are gone after the edge.
    p_en_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en_clr != '0 && en_set == '0) |=> ((en_q & $past(en_clr)) == '0));

    // R4: a software clear with no competing set removes pending bits.
    p_pd_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_clr != '0 && hw_edge == '0 && pd_set == '0) |=> ((pend_q & $past(pd_clr)) == '0));

    // R7: every hardware edge leaves its line pending.
    p_hw_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_edge != '0) |=> ((pend_q & $past(hw_edge)) == $past(hw_edge)));

    // R8: a hardware edge beats a same-cycle software clear.
    p_hw_beats_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((hw_edge & pd_clr) != '0) |=> ((pend_q & $past(hw_edge & pd_clr)) != '0));

endmodule

// File: rtl/irq_prio_bank.sv
// Urgency fields, PW bits per line, four lines per 32-bit word.
// Line 4k+j lives in the top PW bits of byte lane j of word k.
// Assumes wr_idx selects a valid word whenever wr_en is high.
module irq_prio_bank #(
    parameter int NUM_LINES = 32,
    parameter int PW        = 2,
    parameter int IDX_W     = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        idx,
    input  logic [31:0]             wr_data,
    output logic [31:0]             rd_word,
    output logic [NUM_LINES*PW-1:0] prio_flat
);

    localparam logic [7:0]  BYTE_MASK = 8'(((1 << PW) - 1) << (8 - PW));
    localparam logic [31:0] LANE_MASK = {4{BYTE_MASK}};

    logic [PW-1:0] prio_q [NUM_LINES];
    logic          unused_rsvd_bits;

    // Reserved bits of the write data are deliberately dropped.
    assign unused_rsvd_bits = ^(wr_data & ~LANE_MASK);

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        localparam int K = g / 4;
        localparam int J = g % 4;

        // One urgency field: load from its byte lane when its word is written.
        always_ff @(posedge clk) begin
            if (!rst_n)                             prio_q[g] <= '0;
            else if (wr_en && idx == IDX_W'(K))     prio_q[g] <= wr_data[8*J+8-PW +: PW];
        end

        assign prio_flat[g*PW +: PW] = prio_q[g];
    end

    // Read mux: place the four fields of the addressed word in their lanes.
    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (IDX_W'(i / 4) == idx) rd_word[8*(i%4)+8-PW +: PW] = prio_q[i];
        end
    end

    // R5: reserved bits of an urgency word always read zero.
    p_prio_rsvd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_word & ~LANE_MASK) == '0));

    // R6: without a write strobe the fields hold.
    p_prio_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(prio_flat));

endmodule

// File: rtl/irq_pick.sv
// Selects the most urgent pending, enabled line. Lowest urgency value wins,
// and the lower line number wins a tie. The result is registered.
// Assumes cand already combines pending and enable.
module irq_pick #(
    parameter int NUM_LINES = 32,
    parameter int PW        = 2,
    parameter int ID_W      = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_LINES-1:0]    cand,
    input  logic [NUM_LINES*PW-1:0] prio_flat,
    output logic [ID_W-1:0]         pick_id,
    output logic                    pick_valid
);

    logic            best_v;
    logic [ID_W-1:0] best_id;
    logic [PW-1:0]   best_p;

    // Scan downward; "<=" lets a lower line displace an equal-urgency winner.
    always_comb begin
        best_v  = 1'b0;
        best_id = '0;
        best_p  = '1;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (cand[i] && (!best_v || prio_flat[i*PW +: PW] <= best_p)) begin
                best_v  = 1'b1;
                best_id = ID_W'(i);
                best_p  = prio_flat[i*PW +: PW];
            end
        end
    end

    // Register the choice.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pick_valid <= 1'b0;
            pick_id    <= '0;
        end else begin
            pick_valid <= best_v;
            pick_id    <= best_v ? best_id : '0;
        end
    end

    // R9: a presented line was a candidate one cycle earlier.
    p_pick_is_cand_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pick_valid |-> ((($past(cand) >> pick_id) & NUM_LINES'(1)) != '0));

    // R12: the valid flag is low only when no candidate existed.
    p_idle_no_cand_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !pick_valid |-> ($past(cand) == '0 && pick_id == '0));

endmodule

// File: rtl/irq_prio_ctrl.sv
// Top of the interrupt controller register bank.
// - Decodes word addresses into enable, pending and urgency registers.
// - Turns bus writes into set and clear masks.
// - Muxes read data.
// - Wires the registered arbiter.
// Assumes full-word accesses; an address with bits [1:0] not zero is reserved.
module irq_prio_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int PRIO_W    = 2,
    parameter int ADDR_W    = 12
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic                         bus_we,
    input  logic [BUS_DW-1:0]            bus_wdata,
    output logic [BUS_DW-1:0]            bus_rdata,
    input  logic [NUM_LINES-1:0]         irq_in,
    output logic [$clog2(NUM_LINES)-1:0] pick_id,
    output logic                         pick_valid,
    input  logic                         pick_ack
);

    localparam int ID_W       = $clog2(NUM_LINES);
    localparam int PRIO_WORDS = (NUM_LINES + LINES_PER_W - 1) / LINES_PER_W;
    localparam int IDX_W      = (PRIO_WORDS > 1) ? $clog2(PRIO_WORDS) : 1;
    localparam int unsigned PRIO_END = OFS_PRIO + 4 * PRIO_WORDS;

    reg_sel_e                reg_sel;
    logic [IDX_W-1:0]        prio_idx;
    int unsigned             addr_u;
    logic [NUM_LINES-1:0]    en_set, en_clr, pd_set, pd_clr, ack_clr;
    logic [NUM_LINES-1:0]    en_q, pend_q;
    logic [NUM_LINES*PRIO_W-1:0] prio_flat;
    logic [31:0]             prio_rd;

    assign addr_u = 32'(bus_addr);

    // Address decode: exact word matches, plus the urgency word window.
    always_comb begin
        reg_sel  = REG_NONE;
        prio_idx = '0;
        if (bus_addr[1:0] == 2'b00) begin
            if (addr_u == OFS_EN_SET)      reg_sel = REG_EN_SET;
            else if (addr_u == OFS_EN_CLR) reg_sel = REG_EN_CLR;
            else if (addr_u == OFS_PD_SET) reg_sel = REG_PD_SET;
            else if (addr_u == OFS_PD_CLR) reg_sel = REG_PD_CLR;
            else if (addr_u >= OFS_PRIO && addr_u < PRIO_END) begin
                reg_sel  = REG_PRIO;
                prio_idx = IDX_W'((addr_u - OFS_PRIO) >> 2);
            end
        end
    end

    // Write masks, qualified by the strobe and the decoded register.
    always_comb begin
        en_set = (bus_we && reg_sel == REG_EN_SET) ? bus_wdata[NUM_LINES-1:0] : '0;
        en_clr = (bus_we && reg_sel == REG_EN_CLR) ? bus_wdata[NUM_LINES-1:0] : '0;
        pd_set = (bus_we && reg_sel == REG_PD_SET) ? bus_wdata[NUM_LINES-1:0] : '0;
        pd_clr = (bus_we && reg_sel == REG_PD_CLR) ? bus_wdata[NUM_LINES-1:0] : '0;
    end

    // Acknowledge: one-hot clear of the presented line.
    assign ack_clr = (pick_ack && pick_valid) ? (NUM_LINES'(1) << pick_id) : '0;

    // Read mux: aliases share their vector, anything else reads zero.
    always_comb begin
        bus_rdata = '0;
        unique case (reg_sel)
            REG_EN_SET, REG_EN_CLR: bus_rdata[NUM_LINES-1:0] = en_q;
            REG_PD_SET, REG_PD_CLR: bus_rdata[NUM_LINES-1:0] = pend_q;
            REG_PRIO:               bus_rdata = prio_rd;
            default:                bus_rdata = '0;
        endcase
    end

    irq_line_state #(.NUM_LINES(NUM_LINES)) u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_set  (en_set),
        .en_clr  (en_clr),
        .pd_set  (pd_set),
        .pd_clr  (pd_clr),
        .ack_clr (ack_clr),
        .irq_in  (irq_in),
        .en_q    (en_q),
        .pend_q  (pend_q)
    );

    irq_prio_bank #(.NUM_LINES(NUM_LINES), .PW(PRIO_W), .IDX_W(IDX_W)) u_prio (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_we && reg_sel == REG_PRIO),
        .idx       (prio_idx),
        .wr_data   (bus_wdata),
        .rd_word   (prio_rd),
        .prio_flat (prio_flat)
    );

    irq_pick #(.NUM_LINES(NUM_LINES), .PW(PRIO_W), .ID_W(ID_W)) u_pick (
        .clk        (clk),
        .rst_n      (rst_n),
        .cand       (pend_q & en_q),
        .prio_flat  (prio_flat),
        .pick_id    (pick_id),
        .pick_valid (pick_valid)
    );

    // R6: reserved writes leave enable and urgency state untouched.
    p_rsvd_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && reg_sel == REG_NONE) |=> ($stable(en_q) && $stable(prio_flat)));

    // R6: reserved addresses read zero.
    p_rsvd_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == REG_NONE) |-> (bus_rdata == '0));

    // R11: an acknowledge with no competing set clears the presented line.
    p_ack_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pick_ack && pick_valid && !bus_we && $stable(irq_in))
        |=> (((pend_q >> $past(pick_id)) & NUM_LINES'(1)) == '0));

endmodule

// File: tb/tb_irq_prio_ctrl.sv
module tb_irq_prio_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] irq_in = '0;
    logic [4:0]  pick_id;
    logic        pick_valid;
    logic        pick_ack = 1'b0;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    irq_prio_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
        .pick_id(pick_id), .pick_valid(pick_valid), .pick_ack(pick_ack)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic pick_chk(input string req, input logic v, input logic [4:0] id);
        chk({req, " valid"}, 32'(pick_valid), 32'(v));
        chk({req, " id"}, 32'(pick_id), 32'(id));
    endtask

    task automatic t_reset;
        rd_chk("R1 enable", 12'h100, 0);
        rd_chk("R1 pending", 12'h200, 0);
        rd_chk("R1 prio", 12'h41C, 0);
        pick_chk("R1", 1'b0, 5'd0);
    endtask

    task automatic t_enable;
        wr(12'h100, 32'h0000_00F0);
        rd_chk("R3 alias read", 12'h180, 32'h0000_00F0);
        wr(12'h100, 32'h0000_0003);
        rd_chk("R2 set keeps others", 12'h100, 32'h0000_00F3);
        wr(12'h180, 32'h0000_0010);
        rd_chk("R3 clear one", 12'h100, 32'h0000_00E3);
        wr(12'h180, 32'hFFFF_FFFF);
        rd_chk("R3 clear all", 12'h180, 0);
    endtask

    task automatic t_pending;
        wr(12'h200, 32'h8000_0001);
        rd_chk("R4 set read", 12'h280, 32'h8000_0001);
        wr(12'h280, 32'h0000_0001);
        rd_chk("R4 clear one", 12'h200, 32'h8000_0000);
        wr(12'h280, 32'hFFFF_FFFF);
        rd_chk("R4 clear all", 12'h200, 0);
    endtask

    task automatic t_prio;
        wr(12'h404, 32'hFFFF_FFFF);
        rd_chk("R5 reserved bits zero", 12'h404, 32'hC0C0_C0C0);
        wr(12'h41C, 32'h4080_00C0);
        rd_chk("R5 lane placement", 12'h41C, 32'h4080_00C0);
        rd_chk("R5 other word untouched", 12'h400, 0);
    endtask

    task automatic t_reserved;
        wr(12'h100, 32'h0000_0005);
        wr(12'h104, 32'hFFFF_FFFF);
        wr(12'h300, 32'hFFFF_FFFF);
        wr(12'h420, 32'hFFFF_FFFF);
        wr(12'h101, 32'hFFFF_FFFF);
        wr(12'h181, 32'hFFFF_FFFF);
        wr(12'h000, 32'hFFFF_FFFF);
        rd_chk("R6 enable kept", 12'h100, 32'h0000_0005);
        rd_chk("R6 pending kept", 12'h200, 0);
        rd_chk("R6 prio kept", 12'h404, 32'hC0C0_C0C0);
        rd_chk("R6 read zero 0x420", 12'h420, 0);
        rd_chk("R6 read zero unaligned", 12'h102, 0);
        wr(12'h180, 32'hFFFF_FFFF);
    endtask

    task automatic t_hw;
        @(negedge clk);
        irq_in[9] = 1'b1;
        rd_chk("R7 edge sets pending while disabled", 12'h200, 32'h0000_0200);
        @(negedge clk);
        chk("R7 disabled line not picked", 32'(pick_valid), 0);
        wr(12'h280, 32'h0000_0200);
        @(negedge clk);
        rd_chk("R7 held level does not re-set", 12'h200, 0);
        irq_in[9] = 1'b0;
    endtask

    task automatic t_race;
        wr(12'h200, 32'h0000_2000);
        @(negedge clk);
        irq_in[12] = 1'b1;
        bus_addr = 12'h280; bus_wdata = 32'h0000_3000; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        rd_chk("R8 hw set wins, other clear applies", 12'h200, 32'h0000_1000);
        irq_in[12] = 1'b0;
        wr(12'h280, 32'hFFFF_FFFF);
    endtask

    task automatic ack_pulse;
        @(negedge clk);
        pick_ack = 1'b1;
        @(negedge clk);
        pick_ack = 1'b0;
    endtask

    task automatic t_arb;
        wr(12'h400, 32'h0000_0000);
        wr(12'h404, 32'hC040_C080);
        wr(12'h408, 32'hC0C0_40C0);
        wr(12'h100, 32'h0000_0250);
        wr(12'h200, 32'h0000_0258);
        pick_chk("R10 lag after state change", 1'b0, 5'd0);
        @(negedge clk);
        pick_chk("R9 tie goes to lower line", 1'b1, 5'd6);
        ack_pulse();
        pick_chk("R10 pick holds for one cycle after ack", 1'b1, 5'd6);
        rd_chk("R11 ack cleared line 6", 12'h200, 32'h0000_0218);
        pick_chk("R9 next equal-urgency line", 1'b1, 5'd9);
        ack_pulse();
        @(negedge clk);
        pick_chk("R9 less urgent line", 1'b1, 5'd4);
        ack_pulse();
        @(negedge clk);
        pick_chk("R12 disabled pending line ignored", 1'b0, 5'd0);
        rd_chk("R11 only line 3 left", 12'h200, 32'h0000_0008);
        wr(12'h100, 32'h0000_0008);
        @(negedge clk);
        pick_chk("R9 enabled line 3 picked", 1'b1, 5'd3);
        ack_pulse();
        @(negedge clk);
        pick_chk("R12 nothing left", 1'b0, 5'd0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 20000) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<20000 cycles", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_enable();
        t_pending();
        t_prio();
        t_reserved();
        t_hw();
        t_race();
        t_arb();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule